// File: doc/BRIEF.md
# FSK Cassette Bit Serializer

This block turns bytes into a two-tone square wave for recording on audio tape. Each accepted byte is framed with a leading start bit and trailing stop bits and is sent least significant bit first. Every bit occupies the same time slot of four base intervals. A zero is drawn as one slow cycle and a one as two fast cycles at twice that frequency. The single output level inverts at each scheduled edge, and a clock-cycle counter times those edges, so the pitch does not depend on any software loop.

A motor-enable output is raised when the first byte is taken and stays high while frames follow. When no new byte is offered at a frame boundary, the block fills the line with one-bit tone. If no byte arrives within a fixed number of those fill bits, it drops the motor enable and goes quiet. The base interval is `HALF_CYC >> SPEED_SHIFT` clock cycles. The default of 52083 cycles at 250 MHz gives 1200 baud with 1200 Hz and 2400 Hz tones. A nonzero `SPEED_SHIFT` gives a faster variant with the same framing.

Top module: `tape_fsk_tx`

## Requirements
- R1: Every bit lasts exactly 4·B clock cycles, where B = HALF_CYC >> SPEED_SHIFT.
- R2: A zero bit inverts the line at its first cycle and again 2·B cycles later, so its edges are 2·B apart.
- R3: A one bit inverts the line at its first cycle and then every B cycles, giving four edges spaced B apart.
- R4: A frame is a start bit of value 0, then the DATA_BITS data bits least significant bit first, then STOP_BITS stop bits of value 1.
- R5: A byte is taken only on a clock edge where valid_i and ready_o are both high. data_i has no effect at any other time.
- R6: ready_o is high whenever motor_o is low. While motor_o is high, ready_o is high only in the last cycle of a final stop bit or of a fill bit.
- R7: A byte accepted at a frame or fill-bit boundary starts its start bit in the very next cycle, with no gap.
- R8: With no new byte, TAIL_BITS one-tone fill bits follow the last frame. motor_o then falls (FRAME_BITS+TAIL_BITS)·4·B cycles after the accepting edge, where FRAME_BITS = 1+DATA_BITS+STOP_BITS.
- R9: motor_o rises on the same edge that accepts a byte while idle, and the line inverts on that edge as the start bit begins.
- R10: After reset line_o and motor_o are 0 and ready_o is 1.
- R11: While motor_o is low, line_o holds its level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Byte offered |
| data_i | input | DATA_BITS | Byte to send |
| ready_o | output | 1 | Byte can be taken this cycle |
| line_o | output | 1 | Square-wave audio level |
| motor_o | output | 1 | Tape motor enable |

## Verification
The bench samples on falling edges and drives inputs just after rising edges. An acceptance seen at sample n therefore shows up at sample n+1 as the motor rise, the first line edge and the start of the frame. Every line edge is checked against the spacing the previous bit calls for: B for a one or fill bit and 2·B for a zero. This is built from the accepted bytes in order, so framing, bit order and back-to-back joins are covered. The motor fall must land exactly (FRAME_BITS+TAIL_BITS)·4·B samples after the last acceptance. A ready_o pulse while the motor runs must fall on the final cycle of a 4·B slot counted from the motor rise.

// File: rtl/tape_fsk_pkg.sv
package tape_fsk_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FRAME = 2'd1,
    ST_TAIL  = 2'd2
  } tx_state_e;
endpackage

// File: rtl/tape_fsk_timer.sv
module tape_fsk_timer #(
  parameter int BASE_CYC = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  input  logic       clear_i,
  output logic [1:0] qidx_o,
  output logic       tick_o,
  output logic       bit_end_o
);
  localparam int CW = $clog2(BASE_CYC + 1);

  logic [CW-1:0] cnt_q;
  logic [1:0]    q_q;

  assign tick_o    = run_i & (cnt_q == CW'(BASE_CYC - 1));
  assign bit_end_o = tick_o & (q_q == 2'd3);
  assign qidx_o    = q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      q_q   <= '0;
    end else if (clear_i) begin
      cnt_q <= '0;
      q_q   <= '0;
    end else if (run_i) begin
      cnt_q <= tick_o ? '0 : cnt_q + 1'b1;
      if (tick_o) q_q <= q_q + 2'd1;
    end
  end

  // R1
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CW'(BASE_CYC));

  // R1
  quarter_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !clear_i && !tick_o) |=> $stable(q_q));
endmodule

// File: rtl/tape_fsk_shaper.sv
module tape_fsk_shaper (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       qstart_i,
  input  logic [1:0] qnext_i,
  input  logic       bit_i,
  output logic       line_o
);
  logic line_q;
  logic flip;

  // ones flip every quarter, zeros only on even quarters
  assign flip   = qstart_i & (bit_i | ~qnext_i[0]);
  assign line_o = line_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) line_q <= 1'b0;
    else         line_q <= line_q ^ flip;
  end

  // R11
  line_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !qstart_i |=> $stable(line_q));
endmodule

// File: rtl/tape_fsk_framer.sv
module tape_fsk_framer
  import tape_fsk_pkg::*;
#(
  parameter int DATA_BITS = 8,
  parameter int STOP_BITS = 2,
  parameter int TAIL_BITS = 12
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 valid_i,
  input  logic [DATA_BITS-1:0] data_i,
  input  logic                 tick_i,
  input  logic                 bit_end_i,
  input  logic [1:0]           qidx_i,
  output logic                 ready_o,
  output logic                 motor_o,
  output logic                 run_o,
  output logic                 clear_o,
  output logic                 qstart_o,
  output logic [1:0]           qnext_o,
  output logic                 bit_o
);
  localparam int FRAME_BITS = 1 + DATA_BITS + STOP_BITS;
  localparam int KW = $clog2(FRAME_BITS + 1);
  localparam int TW = $clog2(TAIL_BITS + 1);

  tx_state_e            st_q, st_d;
  logic [KW-1:0]        k_q, k_d;
  logic [TW-1:0]        tail_q, tail_d;
  logic [DATA_BITS-1:0] sh_q, sh_d;
  logic                 idle, last_frame, accept;

  assign idle       = (st_q == ST_IDLE);
  assign last_frame = (st_q == ST_FRAME) && (k_q == KW'(FRAME_BITS - 1));
  assign ready_o    = idle | (bit_end_i & ((st_q == ST_TAIL) | last_frame));
  assign accept     = valid_i & ready_o;

  always_comb begin
    st_d   = st_q;
    k_d    = k_q;
    tail_d = tail_q;
    sh_d   = sh_q;
    if (accept) begin
      st_d = ST_FRAME;
      k_d  = '0;
      sh_d = data_i;
    end else if (bit_end_i) begin
      unique case (st_q)
        ST_FRAME: begin
          if (last_frame) begin
            st_d   = ST_TAIL;
            tail_d = '0;
          end else begin
            k_d = k_q + 1'b1;
            if (k_q != '0 && k_q <= KW'(DATA_BITS)) sh_d = sh_q >> 1;
          end
        end
        ST_TAIL: begin
          if (tail_q == TW'(TAIL_BITS - 1)) st_d = ST_IDLE;
          else tail_d = tail_q + 1'b1;
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  // value of the bit that is current after this edge
  always_comb begin
    if (st_d == ST_FRAME && k_d == '0)                     bit_o = 1'b0;
    else if (st_d == ST_FRAME && k_d <= KW'(DATA_BITS))    bit_o = sh_d[0];
    else                                                   bit_o = 1'b1;
  end

  assign qstart_o = (idle & accept) | (tick_i & (st_d != ST_IDLE));
  assign qnext_o  = idle ? 2'd0 : qidx_i + 2'd1;
  assign run_o    = ~idle;
  assign clear_o  = idle & accept;
  assign motor_o  = ~idle;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      k_q    <= '0;
      tail_q <= '0;
      sh_q   <= '0;
    end else begin
      st_q   <= st_d;
      k_q    <= k_d;
      tail_q <= tail_d;
      sh_q   <= sh_d;
    end
  end

  // R5
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle && !valid_i) |=> (st_q == ST_IDLE));

  // R8
  tail_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_TAIL && bit_end_i && !valid_i && tail_q == TW'(TAIL_BITS - 1)) |=> !motor_o);

  // R1
  bit_index_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_FRAME && !bit_end_i) |=> $stable(k_q));
endmodule

// File: rtl/tape_fsk_tx.sv
module tape_fsk_tx #(
  parameter int HALF_CYC    = 52083,
  parameter int SPEED_SHIFT = 0,
  parameter int DATA_BITS   = 8,
  parameter int STOP_BITS   = 2,
  parameter int TAIL_BITS   = 12
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 valid_i,
  input  logic [DATA_BITS-1:0] data_i,
  output logic                 ready_o,
  output logic                 line_o,
  output logic                 motor_o
);
  localparam int BASE_CYC = HALF_CYC >> SPEED_SHIFT;

  logic       run, clear, tick, bit_end, qstart, cur_bit;
  logic [1:0] qidx, qnext;

  tape_fsk_timer #(.BASE_CYC(BASE_CYC)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run),
    .clear_i   (clear),
    .qidx_o    (qidx),
    .tick_o    (tick),
    .bit_end_o (bit_end)
  );

  tape_fsk_framer #(
    .DATA_BITS (DATA_BITS),
    .STOP_BITS (STOP_BITS),
    .TAIL_BITS (TAIL_BITS)
  ) u_framer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (valid_i),
    .data_i    (data_i),
    .tick_i    (tick),
    .bit_end_i (bit_end),
    .qidx_i    (qidx),
    .ready_o   (ready_o),
    .motor_o   (motor_o),
    .run_o     (run),
    .clear_o   (clear),
    .qstart_o  (qstart),
    .qnext_o   (qnext),
    .bit_o     (cur_bit)
  );

  tape_fsk_shaper u_shaper (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .qstart_i (qstart),
    .qnext_i  (qnext),
    .bit_i    (cur_bit),
    .line_o   (line_o)
  );

  // R11
  idle_no_toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!motor_o && !valid_i) |=> $stable(line_o));

  // R9
  motor_start_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(motor_o) |-> (line_o != $past(line_o)));

  // R6
  ready_when_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !motor_o |-> ready_o);
endmodule

// File: tb/sim_tape_fsk_tx.sv
`timescale 1ns/1ps
module sim_tape_fsk_tx;
  localparam int HC = 8, SS = 1, DB = 8, SB = 2, TB = 3;
  localparam int B = HC >> SS;
  localparam int BITC = 4 * B;
  localparam int FRAME = 1 + DB + SB;

  logic clk = 1'b0, rst_ni = 1'b0, valid = 1'b0;
  logic [DB-1:0] data = '0;
  logic ready, line, motor;

  tape_fsk_tx #(.HALF_CYC(HC), .SPEED_SHIFT(SS), .DATA_BITS(DB),
                .STOP_BITS(SB), .TAIL_BITS(TB)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid), .data_i(data),
    .ready_o(ready), .line_o(line), .motor_o(motor));

  always #2 clk = ~clk;

  int checks = 0, errors = 0;
  int exq[$];
  int ncyc = 0, last_tog = 0, last_acc = -100000, sess_start = 0;
  bit mon_on = 0, first_tog = 0, acc_pend = 0, prev_line = 0, prev_motor = 0;
  logic [DB-1:0] acc_byte;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, ncyc);
    end
  endtask

  function automatic void push_bit(input bit v);
    if (v) for (int i = 0; i < 4; i++) exq.push_back(B);
    else   for (int i = 0; i < 2; i++) exq.push_back(2 * B);
  endfunction

  // R4: start 0, data LSB first, stop ones
  function automatic void push_frame(input logic [DB-1:0] b);
    push_bit(1'b0);
    for (int i = 0; i < DB; i++) push_bit(b[i]);
    for (int i = 0; i < SB; i++) push_bit(1'b1);
  endfunction

  always @(negedge clk) begin
    ncyc++;
    if (mon_on) begin
      if (motor && !prev_motor) begin
        chk(ncyc == last_acc + 1, "R9 motor rise after accept", ncyc, last_acc + 1);
        chk(line != prev_line, "R9 edge at start", int'(line), int'(!prev_line));
        first_tog = 1;
        sess_start = ncyc;
      end
      if (!motor && prev_motor) begin
        chk(ncyc == last_acc + 1 + (FRAME + TB) * BITC, "R8 R1 motor fall time",
            ncyc, last_acc + 1 + (FRAME + TB) * BITC);
        chk(exq.size() == 0, "R8 pending bits at fall", exq.size(), 0);
      end
      if (line != prev_line) begin
        if (!motor) chk(0, "R11 edge while idle", 1, 0);
        else if (first_tog) first_tog = 0;
        else begin
          int e;
          e = (exq.size() != 0) ? exq.pop_front() : B;
          chk(ncyc - last_tog == e, "R2/R3/R4/R7 edge spacing", ncyc - last_tog, e);
        end
        last_tog = ncyc;
      end
      if (acc_pend) begin
        push_frame(acc_byte);
        acc_pend = 0;
      end
      if (!motor) chk(ready == 1'b1, "R6 ready when idle", int'(ready), 1);
      else if (ready)
        chk(((ncyc - sess_start) % BITC) == BITC - 1, "R6 ready off boundary",
            (ncyc - sess_start) % BITC, BITC - 1);
      if (valid && ready) begin
        acc_pend = 1;
        acc_byte = data;
        last_acc = ncyc;
      end
    end
    prev_line = line;
    prev_motor = motor;
  end

  task automatic send(input logic [DB-1:0] b);
    @(posedge clk); #1;
    valid = 1'b1;
    data = b;
    forever begin
      @(negedge clk);
      if (ready) break;
    end
    @(posedge clk); #1;
    valid = 1'b0;
    data = DB'($urandom);
  endtask

  // R5: data wiggles while valid is low
  task automatic gap(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      data = DB'($urandom);
    end
  endtask

  bit wd = 0;

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R10
    chk(line == 1'b0, "R10 line reset", int'(line), 0);
    chk(motor == 1'b0, "R10 motor reset", int'(motor), 0);
    chk(ready == 1'b1, "R10 ready reset", int'(ready), 1);
    @(posedge clk); #1;
    rst_ni = 1'b1;
    prev_line = line;
    prev_motor = motor;
    mon_on = 1;
    fork
      begin
        gap(5);
        send(8'h00);                      // all zeros, then full tail (R8)
        gap((FRAME + TB + 2) * BITC);
        send(8'hFF);                      // back to back (R7)
        send(8'hA5);
        gap(BITC + 3);                    // lands inside the tail
        send(8'h01);
        gap(2 * BITC);
        send(8'h80);
        gap((FRAME + TB + 2) * BITC);
        for (int n = 0; n < 40; n++) begin
          int sel;
          send(DB'($urandom));
          sel = $urandom_range(0, 3);
          if (sel == 1) gap($urandom_range(1, (TB + 1) * BITC));
          else if (sel == 2) gap((FRAME + TB + 1) * BITC + $urandom_range(0, 20));
        end
        gap((FRAME + TB + 2) * BITC);
        chk(motor == 1'b0, "R8 idle at end", int'(motor), 0);
      end
      begin
        repeat (150000) @(posedge clk);
        wd = 1;
      end
    join_any
    disable fork;
    if (wd) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule